// File: doc/BRIEF.md
# Programmable Three-Channel Interval Timer

This block holds three independent 16-bit down-counters behind an 8-bit register port with a 2-bit address. Addresses 0, 1 and 2 reach the data port of counters 0, 1 and 2. Address 3 is a write-only control port. All three counters run from the block clock. They step once per clock, and each drives one output pin.

The main use is as a baud-rate clock source. Software writes a packed control word to pick a channel, a byte-access order, a counting mode and binary or BCD counting. It then writes the reload value one byte at a time. The rate-generator and square-wave modes are complete. The terminal-count and strobe modes are decoded but have only a reduced behaviour, because the block has no gate inputs.

Software can read a counter's live value byte by byte. It can also freeze a copy with a latch command and read the copy while the counter keeps running.

Top module: `interval_timer_3ch`

## Requirements
- R1: Control word bits 7-6 pick the target channel, with 0 to 2 meaning counters 0 to 2. The value 3 changes no channel.
- R2: Control bits 5-4 give the access order: 1 means high byte only (low byte becomes 0), 2 means low byte only (high byte becomes 0), 3 means low byte then high byte. The count loads on the first clock edge after the edge that takes the last byte.
- R3: Control bits 3-1 give the mode. Codes 6 and 7 behave exactly as codes 2 and 3.
- R4: In rate mode with reload N ≥ 2, the count runs N down to 1 and then reloads. The output is low only for the one clock in which the count is 1, so the period is N clocks.
- R5: In square mode with reload N, the output is high for (N+1)/2 clocks and low for N/2 clocks (integer division), repeating every N clocks.
- R6: Control bit 0 set selects BCD counting, so the count steps through decimal digit codes. A reload of 0 counts as 65536 in binary and as 10000 in BCD.
- R7: A control word with nonzero access bits drives that channel's output high on the next clock. It stops counting until a full reload is written, and it resets the write byte order so the next data write is taken as the low byte.
- R8: A control word with access bits 0 copies the live count into a hold register; the copy is ignored while a hold is pending. Reads then return the held bytes in the programmed access order until all of them are read. The live count keeps running meanwhile.
- R9: Reads with no hold pending return the live count, low byte then high byte, using a read order separate from the write order. Reading address 3 returns 0.
- R10: Modes 0 and 1 drive the output low from load until the count reaches 0, then hold it high. Modes 4 and 5 drive it low for the single clock at which the count reaches 0. In all four modes the counter wraps and does not reload.
- R11: After reset every output is high, every count reads 0 and no channel counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| rd_en | input | 1 | Read strobe; advances the read order at the rising edge |
| addr | input | 2 | 0-2 counter data ports, 3 control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| tmr_out | output | 3 | One output per counter |

## Verification
A data write or control word takes effect at the rising edge that samples it. A completed reload reaches the counter one edge later, and the output for count N is visible right after that edge; this is phase 0. The bench keeps a cycle counter and records each channel's phase-0 cycle. At every falling edge it compares all three outputs with the pattern the requirements give for the phase reached. Read data is combinational, so it is sampled a moment after the read strobe is driven. A held value reflects the count visible in the cycle when the latch command was driven.

// File: rtl/itimer_pkg.sv
// Shared widths, control-field encodings and helper functions for the
// three-channel interval timer. Assumes 16-bit counters built from 4-bit digits.
package itimer_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NUM_CH = 3;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_MSB   = 2'd1,
        ACC_LSB   = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        OP_TERM,
        OP_RATE,
        OP_SQUARE,
        OP_STROBE
    } op_e;

    // Fold the 3-bit mode code onto the behaviour actually built
    function automatic op_e op_of(input logic [2:0] m);
        case (m)
            3'd2, 3'd6: return OP_RATE;
            3'd3, 3'd7: return OP_SQUARE;
            3'd4, 3'd5: return OP_STROBE;
            default:    return OP_TERM;
        endcase
    endfunction

    // Half of the effective reload (0 means full range) in the active code
    function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] n,
                                                 input logic bcd);
        logic [CNT_W-1:0] h;
        logic             odd;
        h   = '0;
        odd = 1'b0;
        if (n == '0)
            h = bcd ? (CNT_W'(5) << (CNT_W - 4)) : (CNT_W'(1) << (CNT_W - 1));
        else if (!bcd)
            h = n >> 1;
        else
            for (int i = DIGITS - 1; i >= 0; i--) begin
                h[4*i +: 4] = {1'b0, n[4*i+1 +: 3]} + (odd ? 4'd5 : 4'd0);
                odd = n[4*i];
            end
        return h;
    endfunction
endpackage

// File: rtl/itimer_dec.sv
// Decrement-by-one unit for binary or packed BCD values.
// Assumes BCD inputs hold valid digits; BCD zero wraps to all nines.
module itimer_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] dec
);
    localparam int ND = W / 4;

    logic [ND:0]  brw;
    logic [W-1:0] bcd_res;

    assign brw[0] = 1'b1;

    // One digit stage per nibble, borrow rippling upward
    for (genvar gi = 0; gi < ND; gi++) begin : g_digit
        logic [3:0] d;
        assign d = val[4*gi +: 4];
        assign bcd_res[4*gi +: 4] = !brw[gi] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
        assign brw[gi+1] = brw[gi] && (d == 4'd0);
    end

    // Pick the coded or plain result
    always_comb dec = bcd ? bcd_res : val - W'(1);
endmodule

// File: rtl/itimer_channel.sv
// One counter channel: holds its configuration, assembles the reload from byte
// writes, counts down, shapes its output and serves byte reads of the live or
// held count. Assumes strobes are one-cycle and already decoded by address.
module itimer_channel
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_bits,
    input  logic              data_we,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              cnt_out
);
    logic [2:0]       mode_q;
    acc_e             acc_q;
    logic             bcd_q;
    logic [CNT_W-1:0] reload_q, top_q, half_q, count_q, hold_val_q;
    logic             wr_hi_q, rd_hi_q, hold_q, pend_q, run_q, out_q;

    logic             cfg_prog, cfg_latch, load_done, wrap, out_nx;
    logic [CNT_W-1:0] reload_nx, dec_v, nc, src;
    op_e              op;

    assign cfg_prog  = cfg_we && (cfg_bits[5:4] != ACC_LATCH);
    assign cfg_latch = cfg_we && (cfg_bits[5:4] == ACC_LATCH);
    assign op        = op_of(mode_q);
    assign wrap      = (op == OP_RATE) || (op == OP_SQUARE);
    assign load_done = data_we && ((acc_q != ACC_BOTH) || wr_hi_q);

    itimer_dec #(.W(CNT_W)) u_dec (.val(count_q), .bcd(bcd_q), .dec(dec_v));

    // Next reload value from the incoming byte and the access order
    always_comb begin
        case (acc_q)
            ACC_MSB: reload_nx = {wbyte, 8'h00};
            ACC_LSB: reload_nx = {8'h00, wbyte};
            default: reload_nx = wr_hi_q ? {wbyte, reload_q[7:0]} : {reload_q[15:8], wbyte};
        endcase
    end

    // Next count and next output level for a counting clock
    always_comb begin
        nc = (wrap && count_q == CNT_W'(1)) ? top_q : dec_v;
        case (op)
            OP_RATE:   out_nx = (nc != CNT_W'(1));
            OP_SQUARE: out_nx = (nc == '0) || (nc > half_q);
            OP_TERM:   out_nx = out_q || (nc == '0);
            default:   out_nx = (nc != '0);
        endcase
    end

    // Configuration fields, reload assembly and write byte order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 3'd0;
            acc_q    <= ACC_BOTH;
            bcd_q    <= 1'b0;
            wr_hi_q  <= 1'b0;
            reload_q <= '0;
        end else if (cfg_prog) begin
            mode_q  <= cfg_bits[3:1];
            acc_q   <= acc_e'(cfg_bits[5:4]);
            bcd_q   <= cfg_bits[0];
            wr_hi_q <= 1'b0;
        end else if (data_we) begin
            reload_q <= reload_nx;
            wr_hi_q  <= (acc_q == ACC_BOTH) ? !wr_hi_q : 1'b0;
        end
    end

    // Counter, load sequencing and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            top_q   <= '0;
            half_q  <= '0;
            out_q   <= 1'b1;
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else if (cfg_prog) begin
            out_q  <= 1'b1;
            run_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (pend_q) begin
            count_q <= reload_q;
            top_q   <= reload_q;
            half_q  <= half_of(reload_q, bcd_q);
            run_q   <= 1'b1;
            pend_q  <= load_done;
            out_q   <= (op != OP_TERM);
        end else begin
            if (load_done) pend_q <= 1'b1;
            if (run_q) begin
                count_q <= nc;
                out_q   <= out_nx;
            end
        end
    end

    // Hold register and read byte order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hi_q    <= 1'b0;
            hold_q     <= 1'b0;
            hold_val_q <= '0;
        end else if (cfg_prog) begin
            rd_hi_q <= 1'b0;
            hold_q  <= 1'b0;
        end else if (cfg_latch && !hold_q) begin
            hold_val_q <= count_q;
            hold_q     <= 1'b1;
            rd_hi_q    <= 1'b0;
        end else if (data_rd) begin
            if (hold_q && acc_q != ACC_BOTH) begin
                hold_q <= 1'b0;
            end else if (hold_q && rd_hi_q) begin
                hold_q  <= 1'b0;
                rd_hi_q <= 1'b0;
            end else begin
                rd_hi_q <= !rd_hi_q;
            end
        end
    end

    // Byte presented to the read port
    always_comb begin
        src = hold_q ? hold_val_q : count_q;
        if (hold_q && acc_q == ACC_MSB)      rd_byte = src[15:8];
        else if (hold_q && acc_q == ACC_LSB) rd_byte = src[7:0];
        else                                 rd_byte = rd_hi_q ? src[15:8] : src[7:0];
    end

    assign cnt_out = out_q;

    AST_OUT_HIGH_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prog |=> out_q); // R7
    AST_RATE_ONE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && op == OP_RATE && !out_q && top_q != CNT_W'(1)) |=> out_q); // R4
    AST_SQUARE_FALL_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SQUARE && $fell(out_q)) |-> (count_q == half_q)); // R5
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !data_rd && !cfg_prog) |=> (hold_q && $stable(hold_val_q))); // R8
endmodule

// File: rtl/interval_timer_3ch.sv
// Top level: decodes the 2-bit register address and the channel field of the
// control word, fans strobes out to three counter channels and muxes read data.
// Assumes one access per cycle; reads of address 3 return zero.
module interval_timer_3ch
    import itimer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [2:0]  tmr_out
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic [NUM_CH-1:0] cfg_we_v;
    logic [BYTE_W-1:0] rd_bytes [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic cfg_we_g, data_we_g, data_rd_g;
        assign cfg_we_g  = wr_en && (addr == CTRL_ADDR) && (wdata[7:6] == 2'(g));
        assign data_we_g = wr_en && (addr == 2'(g));
        assign data_rd_g = rd_en && (addr == 2'(g));
        assign cfg_we_v[g] = cfg_we_g;

        itimer_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we_g),
            .cfg_bits (wdata[5:0]),
            .data_we  (data_we_g),
            .data_rd  (data_rd_g),
            .wbyte    (wdata),
            .rd_byte  (rd_bytes[g]),
            .cnt_out  (tmr_out[g])
        );
    end

    // Read data mux by address, zero for the control port
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (addr == 2'(i)) rdata = rd_bytes[i];
    end

    AST_ONE_CFG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we_v)); // R1
endmodule

// File: tb/interval_timer_3ch_test.sv
module interval_timer_3ch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] tmr_out;

    int  nchk = 0, nbad = 0, cyc = 0, last_wr_cyc = 0;
    int  load_cyc [3], op_t [3], topn [3];
    bit  bcd_t [3], idle_t [3];
    bit  done = 1'b0;

    interval_timer_3ch uut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int bcd2int(logic [15:0] v);
        return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
    endfunction

    function automatic logic [15:0] int2bcd(int v);
        return {4'(v/1000%10), 4'(v/100%10), 4'(v/10%10), 4'(v%10)};
    endfunction

    function automatic int op_from(logic [7:0] cw);
        case (cw[3:1])
            3'd2, 3'd6: return 1;
            3'd3, 3'd7: return 2;
            3'd4, 3'd5: return 3;
            default:    return 0;
        endcase
    endfunction

    // Expected output of a channel at phase p after its load edge
    function automatic bit exp_out(int ch, int p);
        int n = topn[ch];
        int m = bcd_t[ch] ? 10000 : 65536;
        if (idle_t[ch]) return 1'b1;
        case (op_t[ch])
            1: return (p % n) != n - 1;
            2: return (p % n) < (n + 1) / 2;
            0: return p >= n;
            default: return !(p >= n && ((p - n) % m) == 0);
        endcase
    endfunction

    // Expected count of a wrapping channel at phase p
    function automatic logic [15:0] cnt_at(int ch, int p);
        int e = topn[ch] - (p % topn[ch]);
        e = e % (bcd_t[ch] ? 10000 : 65536);
        return bcd_t[ch] ? int2bcd(e) : 16'(e);
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        last_wr_cyc = cyc;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v, output int at);
        @(negedge clk);
        at = cyc;
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic note(int ch, logic [7:0] cw, logic [15:0] val);
        int x;
        op_t[ch]  = op_from(cw);
        bcd_t[ch] = cw[0];
        x = cw[0] ? bcd2int(val) : int'(val);
        topn[ch]  = (x != 0) ? x : (cw[0] ? 10000 : 65536);
        idle_t[ch] = 1'b0;
        load_cyc[ch] = cyc + 1;
    endtask

    task automatic setup(int ch, logic [7:0] cw, logic [15:0] val);
        wr(2'd3, cw);
        idle_t[ch] = 1'b1;
        wr(2'(ch), val[7:0]);
        wr(2'(ch), val[15:8]);
        note(ch, cw, val);
    endtask

    task automatic setup1(int ch, logic [7:0] cw, logic [7:0] b);
        wr(2'd3, cw);
        idle_t[ch] = 1'b1;
        wr(2'(ch), b);
        note(ch, cw, (cw[5:4] == 2'd1) ? {b, 8'h00} : {8'h00, b});
    endtask

    task automatic check_all(int n, string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int ch = 0; ch < 3; ch++)
                chk(req, tmr_out[ch], exp_out(ch, cyc - load_cyc[ch]));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: run did not end act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [7:0] v, lo, hi;
        int at, pl;
        void'($urandom(32'd20240611));
        for (int ch = 0; ch < 3; ch++) begin
            idle_t[ch] = 1'b1; load_cyc[ch] = 0; topn[ch] = 1; op_t[ch] = 0; bcd_t[ch] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        chk("R11 outputs high", tmr_out, 3'b111);
        rd(2'd0, v, at);
        chk("R11 count zero", v, 0);
        rd(2'd3, v, at);
        chk("R9 control read zero", v, 0);
        check_all(5, "R11 idle");

        // R5 R3 standard set-up words, mixed odd and even reloads
        setup(0, 8'h36, 16'h01A0);
        setup(1, 8'h76, 16'h0007);
        setup(2, 8'hB6, 16'h0004);
        check_all(900, "R5 square");

        // R4 rate, and R3 alias codes 6 and 7
        setup(1, 8'h74, 16'h0005);
        check_all(30, "R4 rate");
        setup(1, 8'h7C, 16'h0003);
        setup(0, 8'h3E, 16'h0009);
        check_all(40, "R3 alias codes");

        // R1 reserved channel field
        wr(2'd3, 8'hF4);
        wr(2'd3, 8'hC0);
        check_all(30, "R1 reserved ignored");

        // R8 latch with two-byte order, live count keeps running
        setup(0, 8'h36, 16'd1000);
        check_all(20, "R5 square");
        wr(2'd3, 8'h00);
        pl = last_wr_cyc - load_cyc[0];
        repeat (3) @(negedge clk);
        rd(2'd0, lo, at);
        rd(2'd0, hi, at);
        chk("R8 held low byte", lo, cnt_at(0, pl) & 16'hFF);
        chk("R8 held high byte", hi, cnt_at(0, pl) >> 8);
        // R9 live reads
        rd(2'd0, lo, at);
        chk("R9 live low byte", lo, cnt_at(0, at - load_cyc[0]) & 16'hFF);
        rd(2'd0, hi, at);
        chk("R9 live high byte", hi, cnt_at(0, at - load_cyc[0]) >> 8);
        check_all(10, "R8 live output");

        // R2 low-only access, latched single-byte read
        setup1(2, 8'hA4, 8'h06);
        check_all(20, "R2 low byte only");
        wr(2'd3, 8'h80);
        pl = last_wr_cyc - load_cyc[2];
        rd(2'd2, v, at);
        chk("R8 held low-only", v, cnt_at(2, pl) & 16'hFF);
        rd(2'd2, v, at);
        chk("R9 live after hold", v, cnt_at(2, at - load_cyc[2]) & 16'hFF);
        // R2 high-only access
        setup1(2, 8'h94, 8'h01);
        check_all(600, "R2 high byte only");

        // R6 BCD square and rate, with held BCD count
        setup(1, 8'h77, 16'h0015);
        check_all(50, "R6 bcd square");
        wr(2'd3, 8'h40);
        pl = last_wr_cyc - load_cyc[1];
        rd(2'd1, lo, at);
        rd(2'd1, hi, at);
        chk("R6 held bcd count", {hi, lo}, cnt_at(1, pl));
        setup(1, 8'h75, 16'h0012);
        check_all(40, "R6 bcd rate");

        // R7 control word drives high, stops, resets write order
        setup(0, 8'h30, 16'd20);
        check_all(3, "R10 terminal low");
        wr(2'd3, 8'h30);
        idle_t[0] = 1'b1;
        chk("R7 high after control", tmr_out[0], 1);
        wr(2'd0, 8'h33);
        wr(2'd3, 8'h30);
        check_all(5, "R7 stopped");
        wr(2'd0, 8'h05);
        wr(2'd0, 8'h00);
        note(0, 8'h30, 16'h0005);
        check_all(30, "R10 terminal count");

        // R10 strobe mode
        setup(2, 8'hB8, 16'h0003);
        check_all(20, "R10 strobe");

        // Random rate and square set-ups
        for (int it = 0; it < 12; it++) begin
            int ch = $urandom % 3;
            int n = 2 + ($urandom % 59);
            logic [2:0] m;
            bit b = $urandom % 2;
            case ($urandom % 4)
                0: m = 3'd2;
                1: m = 3'd3;
                2: m = 3'd6;
                default: m = 3'd7;
            endcase
            setup(ch, {2'(ch), 2'b11, m, b}, b ? int2bcd(n) : 16'(n));
            check_all(3 * n + 5, "R5 R4 random");
        end

        // R6 zero reload in BCD and binary
        setup(0, 8'h37, 16'h0000);
        check_all(10010, "R6 bcd zero reload");
        setup(0, 8'h34, 16'h0000);
        check_all(65540, "R6 binary zero reload");

        finish_run();
    end
endmodule